// File: doc/BRIEF.md
# Generation-Tagged ASID Allocator

This block hands out hardware address-space tags from a small pool and lets software keep a wider per-context identifier. Each identifier holds a generation number in its upper bits and a hardware ASID in its lower `ASID_W` bits. When a CPU switches to a context, it presents the context's stored identifier. The block returns the identifier the context must use from now on, and says whether that CPU must invalidate its local TLB before it runs. The caller writes the returned identifier back into the context. An identifier of zero marks a context that has never received a tag.

A bitmap records which hardware ASIDs are already taken in the current generation. The search for a free tag never wraps. When no free tag remains at or above the search start, the block does not fail. It moves to a new generation, clears the bitmap and marks every CPU as owing a TLB invalidation. Each CPU then learns of that debt the next time it requests a switch.

The control is one state machine with five states:
- IDLE accepts a request.
- CHECK classifies the presented identifier.
- SEARCH looks for a free tag.
- ROLL starts a new generation.
- REPLY presents the result for one cycle.

The transitions are:
- IDLE→CHECK on an accepted request.
- CHECK→REPLY when the identifier is current or its tag can be reused.
- CHECK→SEARCH otherwise.
- SEARCH→REPLY when a tag is found.
- SEARCH→ROLL when none is found.
- ROLL→SEARCH always.
- REPLY→IDLE always.

Top module: `asid_gen_alloc`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `flush_pend` is all zeros.
- R2: An identifier whose bits above `ASID_W` equal the current generation is returned unchanged.
- R3: A stale nonzero identifier keeps its low `ASID_W` bits if that tag is nonzero and free. The tag is then marked taken, and the upper bits are replaced by the current generation.
- R4: Otherwise the lowest free tag at or above the search start is taken and returned with the current generation. That tag becomes the new search start. Tags below the start are not considered.
- R5: Hardware ASID 0 is never returned, and an identifier of 0 always receives a fresh tag.
- R6: When no free tag exists at or above the start, the following happen:
  - the generation increases by one;
  - every tag is freed;
  - all `flush_pend` bits are set;
  - the search restarts at tag 1.
- R7: `rsp_flush` equals the requesting CPU's `flush_pend` bit, and that bit is then cleared. Other CPUs' bits are untouched.
- R8: `req_ready` is low from acceptance until the reply has been given. Each accepted request yields exactly one `rsp_valid` pulse.
- R9: The reply arrives a fixed number of clock edges after the accepting edge, counting that edge:
  - 2 edges for the current and reuse cases;
  - 3 edges after a search that finds a tag;
  - 5 edges after a generation rollover.
- R10: The generation is 1 after reset. A generation that would wrap to 0 becomes 1, so a current identifier is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Switch request present |
| req_ready | output | 1 | Block can accept a request |
| req_cpu | input | CPU_W | Index of the requesting CPU |
| req_id | input | ID_W | Context's stored identifier |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_id | output | ID_W | Identifier to store back and use |
| rsp_flush | output | 1 | Requesting CPU must invalidate its local TLB |
| flush_pend | output | NCPU | Per-CPU deferred invalidation flags |

## Verification
Each result is due a fixed number of edges after the accepting edge, counting that edge:
- 2 edges when the identifier is current or its tag is reused;
- 3 edges after a search;
- 5 edges after a rollover.

The bench applies inputs on falling edges and counts the rising edges until `rsp_valid` appears on a falling-edge sample. It compares that count with the latency its model predicts. `rsp_id` and `rsp_flush` are checked in the same sample. The flag vector and `req_ready` are checked one edge later, once REPLY has returned to IDLE and the requester's flag has been cleared.

// File: rtl/asid_alloc_pkg.sv
package asid_alloc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SEARCH,
        ST_ROLL,
        ST_REPLY
    } alloc_state_e;
endpackage

// File: rtl/asid_free_finder.sv
module asid_free_finder #(
    parameter int ASID_W = 4,
    localparam int NA = 1 << ASID_W
) (
    input  logic [NA-1:0]     used,
    input  logic [ASID_W-1:0] start,
    output logic              found,
    output logic [ASID_W-1:0] idx
);
    logic [NA-1:0] cand;

    // A slot is a candidate when it is free and at or above the start.
    // Slot 0 is never a candidate.
    generate
        for (genvar g = 0; g < NA; g++) begin : g_cand
            if (g == 0) begin : g_zero
                assign cand[g] = 1'b0;
            end else begin : g_rest
                assign cand[g] = !used[g] && (ASID_W'(g) >= start);
            end
        end
    endgenerate

    // Lowest candidate wins: scan downward so the last hit is the lowest.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NA - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = ASID_W'(i);
            end
        end
    end

    // R4
    always_comb begin
        if (found) begin
            found_free_chk: assert (!used[idx] && idx >= start && idx != '0);
        end
    end
endmodule

// File: rtl/asid_flush_flags.sv
module asid_flush_flags #(
    parameter int NCPU = 4,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_all,
    input  logic             clr_en,
    input  logic [CPU_W-1:0] clr_idx,
    output logic [NCPU-1:0]  flags
);
    // One flag per CPU: set together on rollover, cleared one at a time.
    generate
        for (genvar c = 0; c < NCPU; c++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flags[c] <= 1'b0;
                end else if (set_all) begin
                    flags[c] <= 1'b1;
                end else if (clr_en && clr_idx == CPU_W'(c)) begin
                    flags[c] <= 1'b0;
                end
            end
        end
    endgenerate

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_all) |=> !flags[$past(clr_idx)]);
endmodule

// File: rtl/asid_gen_alloc.sv
module asid_gen_alloc
    import asid_alloc_pkg::*;
#(
    parameter int ASID_W = 4,
    parameter int NCPU   = 4,
    parameter int ID_W   = 12,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CPU_W-1:0] req_cpu,
    input  logic [ID_W-1:0]  req_id,
    output logic             rsp_valid,
    output logic [ID_W-1:0]  rsp_id,
    output logic             rsp_flush,
    output logic [NCPU-1:0]  flush_pend
);
    localparam int NA    = 1 << ASID_W;
    localparam int GEN_W = ID_W - ASID_W;

    alloc_state_e state_q, state_d;

    logic [CPU_W-1:0]  cpu_q;
    logic [ID_W-1:0]   id_q;
    logic [ID_W-1:0]   new_id_q;
    logic [GEN_W-1:0]  gen_q;
    logic [NA-1:0]     used_q;
    logic [ASID_W-1:0] start_q;

    logic [ASID_W-1:0] old_low;
    logic              is_current;
    logic              reuse_ok;
    logic              f_found;
    logic [ASID_W-1:0] f_idx;
    logic [GEN_W-1:0]  gen_inc;
    logic              set_all;
    logic              clr_en;

    // Classification of the latched identifier.
    assign old_low    = id_q[ASID_W-1:0];
    assign is_current = ((id_q ^ {gen_q, {ASID_W{1'b0}}}) >> ASID_W) == '0;
    assign reuse_ok   = (id_q != '0) && (old_low != '0) && !used_q[old_low];

    // Next generation; skip 0 on wrap so a current identifier is never 0.
    assign gen_inc = (gen_q + GEN_W'(1) == '0) ? GEN_W'(1) : gen_q + GEN_W'(1);

    asid_free_finder #(.ASID_W(ASID_W)) u_find (
        .used  (used_q),
        .start (start_q),
        .found (f_found),
        .idx   (f_idx)
    );

    asid_flush_flags #(.NCPU(NCPU)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_all (set_all),
        .clr_en  (clr_en),
        .clr_idx (cpu_q),
        .flags   (flush_pend)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_CHECK;
            ST_CHECK:  state_d = (is_current || reuse_ok) ? ST_REPLY : ST_SEARCH;
            ST_SEARCH: state_d = f_found ? ST_REPLY : ST_ROLL;
            ST_ROLL:   state_d = ST_SEARCH;
            ST_REPLY:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_q    <= '0;
            id_q     <= '0;
            new_id_q <= '0;
            gen_q    <= GEN_W'(1);
            used_q   <= NA'(1);
            start_q  <= ASID_W'(1);
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cpu_q <= req_cpu;
                        id_q  <= req_id;
                    end
                end
                ST_CHECK: begin
                    if (is_current) begin
                        new_id_q <= id_q;
                    end else if (reuse_ok) begin
                        used_q[old_low] <= 1'b1;
                        new_id_q        <= {gen_q, old_low};
                    end
                end
                ST_SEARCH: begin
                    if (f_found) begin
                        used_q[f_idx] <= 1'b1;
                        start_q       <= f_idx;
                        new_id_q      <= {gen_q, f_idx};
                    end
                end
                ST_ROLL: begin
                    gen_q   <= gen_inc;
                    used_q  <= NA'(1);
                    start_q <= ASID_W'(1);
                end
                ST_REPLY: ;
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_REPLY);
        rsp_id    = new_id_q;
        rsp_flush = flush_pend[cpu_q];
        set_all   = (state_q == ST_ROLL);
        clr_en    = (state_q == ST_REPLY);
    end

    // R8
    one_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

    // R5
    asid_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_id[ASID_W-1:0] != '0));

    // R10
    gen_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_id[ID_W-1:ASID_W] == gen_q));

    // R6
    roll_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROLL) |=> ((&flush_pend) && gen_q != $past(gen_q)));

    // R2
    current_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && is_current) |=> (rsp_valid && rsp_id == $past(id_q)));
endmodule

// File: tb/sim_asid_gen_alloc.sv
module sim_asid_gen_alloc;
    localparam int CLK_PERIOD = 10;
    localparam int ASID_W = 4;
    localparam int NCPU   = 4;
    localparam int ID_W   = 12;
    localparam int CPU_W  = 2;
    localparam int NA     = 1 << ASID_W;
    localparam int NCTX   = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [CPU_W-1:0] req_cpu = '0;
    logic [ID_W-1:0]  req_id = '0;
    logic             rsp_valid;
    logic [ID_W-1:0]  rsp_id;
    logic             rsp_flush;
    logic [NCPU-1:0]  flush_pend;

    asid_gen_alloc #(.ASID_W(ASID_W), .NCPU(NCPU), .ID_W(ID_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cpu(req_cpu), .req_id(req_id), .rsp_valid(rsp_valid),
        .rsp_id(rsp_id), .rsp_flush(rsp_flush), .flush_pend(flush_pend)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    // Reference model state.
    int m_gen;
    bit m_used [NA];
    int m_start;
    bit [NCPU-1:0] m_pend;
    logic [ID_W-1:0] ctx [NCTX];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not complete (actual %0d cycles, expected < 150000)", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int model_search();
        for (int i = m_start; i < NA; i++) begin
            if (i != 0 && !m_used[i]) return i;
        end
        return -1;
    endfunction

    // Predicts result, flush and latency per R2-R7, R9, R10; updates model.
    task automatic model_step(input int cpu, input logic [ID_W-1:0] id,
                              output logic [ID_W-1:0] e_id, output bit e_fl,
                              output int e_lat);
        logic [ID_W-1:0] gfull;
        int low, f;
        gfull = ID_W'(m_gen << ASID_W);
        low   = int'(id[ASID_W-1:0]);
        if (((id ^ gfull) >> ASID_W) == 0) begin
            e_id = id; e_lat = 2;
        end else if (id != 0 && low != 0 && !m_used[low]) begin
            m_used[low] = 1'b1; e_id = gfull | ID_W'(low); e_lat = 2;
        end else begin
            f = model_search();
            e_lat = 3;
            if (f < 0) begin
                m_gen = (m_gen + 1) % (1 << (ID_W - ASID_W));
                if (m_gen == 0) m_gen = 1;
                for (int i = 0; i < NA; i++) m_used[i] = 1'b0;
                m_pend = '1;
                m_start = 1;
                f = model_search();
                e_lat = 5;
                gfull = ID_W'(m_gen << ASID_W);
            end
            m_used[f] = 1'b1; m_start = f;
            e_id = gfull | ID_W'(f);
        end
        e_fl = m_pend[cpu];
        m_pend[cpu] = 1'b0;
    endtask

    task automatic transact(input int cpu, input logic [ID_W-1:0] id,
                            output logic [ID_W-1:0] got);
        logic [ID_W-1:0] e_id;
        bit e_fl;
        int e_lat, n;
        model_step(cpu, id, e_id, e_fl, e_lat);
        @(negedge clk);
        check("R8 ready before request", req_ready, 1);
        req_valid = 1'b1; req_cpu = CPU_W'(cpu); req_id = id;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!rsp_valid && n < 20) begin
            check("R8 ready low while busy", req_ready, 0);
            @(negedge clk);
            n++;
        end
        check("R9 reply latency", n, e_lat);
        check("R2 R3 R4 R5 R10 returned identifier", rsp_id, e_id);
        check("R7 flush indication", rsp_flush, e_fl);
        got = rsp_id;
        @(negedge clk);
        check("R8 single reply pulse", rsp_valid, 0);
        check("R6 R7 pending flags", flush_pend, m_pend);
    endtask

    initial begin
        logic [ID_W-1:0] got;
        void'($urandom(32'h5EED_0A51));
        m_gen = 1; m_start = 1; m_pend = '0;
        for (int i = 0; i < NA; i++) m_used[i] = 1'b0;
        for (int i = 0; i < NCTX; i++) ctx[i] = '0;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready after reset", req_ready, 1);
        check("R1 no reply after reset", rsp_valid, 0);
        check("R1 flags clear after reset", flush_pend, 0);
        rst_n = 1'b1;

        // R5 R10: fresh context gets generation 1, tag 1.
        transact(0, '0, got);
        check("R5 R10 first identifier", got, 12'h011);
        // R2: current identifier kept.
        transact(1, got, got);
        check("R2 unchanged", got, 12'h011);
        // R3: stale identifier with a free tag keeps its tag.
        transact(2, 12'h003, got);
        check("R3 reuse tag", got, 12'h013);
        // R5: stale identifier with tag 0 searches instead.
        transact(3, 12'h020, got);
        check("R4 R5 search from start", got, 12'h012);
        // R4: search is from the last allocation (3 was just taken at index 1..2 path).
        transact(0, '0, got);
        check("R4 next search result", got, 12'h014);

        // Exhaust the pool: 11 more fresh contexts fill tags 5..15, then rollover.
        for (int i = 0; i < 11; i++) transact(i % NCPU, '0, got);
        transact(1, '0, got);
        check("R6 rollover identifier", got, 12'h021);
        check("R6 all other flags set", flush_pend, 4'b1101);

        // Random mix of contexts and CPUs.
        for (int t = 0; t < 600; t++) begin
            int k, c;
            k = int'($urandom % NCTX);
            c = int'($urandom % NCPU);
            if (($urandom % 16) == 0) ctx[k] = '0;
            transact(c, ctx[k], got);
            ctx[k] = got;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule